// File: doc/BRIEF.md
# Convert-Pulse Byte Readout Sequencer

This block is the host-facing control interface of a 22-bit integrating converter whose 24-bit result is read over an 8-bit bus. One active-low convert line does two jobs. A falling edge seen while the unit is idle starts a conversion. Each of the next two falling edges advances the readout by one byte. A 2-bit status code tells the host which byte is being presented. The converter core sits behind a start/done/result handshake. The data outputs carry a drive enable that follows the active-low output enable, which stands in for a high-impedance bus.

An active-low zeroing input starts a timed zeroing interval. For the first part of that interval the status outputs are undriven, which is modelled with a status enable. The status is then driven to 00 until zeroing ends. The same interval runs by itself after reset. Both asynchronous inputs pass through a synchronizer and then a minimum-low-time filter. All intervals are parameters counted in clock cycles.

Top module: `cnv_byte_seq`

## Requirements
- R1: A convert pulse is a falling edge of `cnv_n` that stays low for at least `DEB_CYC` consecutive sampled cycles after synchronization. A shorter low level is ignored.
- R2: A pulse while the status is 11 sets `core_start` high for exactly one cycle and sets the status to 00 (conversion in progress).
- R3: Convert pulses are ignored while the status is 00, both during a conversion and during zeroing. `core_done` is ignored outside a conversion.
- R4: When `core_done` is high during a conversion, `data_q` takes `core_result[23:16]` and the status becomes 01.
- R5: A pulse at status 01 loads `core_result[15:8]` and sets status 10. A pulse at status 10 loads `core_result[7:0]` and sets status 11. Both bytes come from the result captured when `core_done` was high, so later changes on `core_result` have no effect.
- R6: `bus_en` is high exactly while `oe_n` is low. The byte on `data_q` does not depend on `oe_n`.
- R7: A filtered low on `az_n` enters zeroing from any state and holds `core_zero` high. `stat_en` is low for the first `FLOAT_CYC` cycles of the interval. After that, the status is driven as 00.
- R8: Zeroing lasts `ZERO_CYC` cycles, counted from the cycle in which the filtered `az_n` returns high. Holding `az_n` low extends it. At the end of zeroing the status becomes 11.
- R9: After reset a zeroing interval runs without any request, and `data_q` reads 00.
- R10: `data_q` changes only on a status change. It keeps its value through zeroing and through ignored pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_n | input | 1 | Active-low convert line, asynchronous |
| az_n | input | 1 | Active-low zeroing request, asynchronous |
| oe_n | input | 1 | Active-low output enable for the data bus |
| core_result | input | 3*BYTE_W | Result word from the converter core |
| core_done | input | 1 | Core signals that the result is valid |
| core_start | output | 1 | One-cycle start strobe to the core |
| core_zero | output | 1 | High while zeroing runs |
| data_q | output | BYTE_W | Byte presented on the bus |
| bus_en | output | 1 | Data bus drive enable |
| stat | output | 2 | Status code {S1,S0} |
| stat_en | output | 1 | Status drive enable (low = floating) |

## Verification
The bench builds the block with a 4-cycle filter, a 5-cycle float window and a 20-cycle zeroing interval. With these values the filter boundary, the float edge and the end of zeroing each lie a few cycles from stimulus, so they can be hit exactly. This lets a full three-byte readout be swept over sixteen result words, including all-zero, all-one and mid-scale. Every sweep also tries pulses that are too short, pulses during a conversion and stray done strobes. A zeroing request in the middle of a readout, held past the filter time, checks that the interval is extended and measured from release.

// File: rtl/cnv_byte_seq.sv
module cnv_byte_seq #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYC     = 500,
  parameter int FLOAT_CYC   = 3_000_000,
  parameter int ZERO_CYC    = 40_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnv_n,
  input  logic                az_n,
  input  logic                oe_n,
  input  logic [3*BYTE_W-1:0] core_result,
  input  logic                core_done,
  output logic                core_start,
  output logic                core_zero,
  output logic [BYTE_W-1:0]   data_q,
  output logic                bus_en,
  output logic [1:0]          stat,
  output logic                stat_en
);

  localparam int DW = $clog2(DEB_CYC + 1);
  localparam int TW = $clog2(ZERO_CYC + 1);

  typedef enum logic [2:0] {ST_ZERO, ST_BUSY, ST_HI, ST_MID, ST_LO} st_t;

  st_t st;
  logic [SYNC_STAGES-1:0] cnv_sh, az_sh;
  logic [DW-1:0] cnv_cnt, az_cnt;
  logic [TW-1:0] tmr;
  logic [2*BYTE_W-1:0] hold;
  logic [BYTE_W-1:0] out_r;
  logic start_r;
  logic cnv_s, az_s, cnv_evt, az_lo;

  assign cnv_s   = cnv_sh[SYNC_STAGES-1];
  assign az_s    = az_sh[SYNC_STAGES-1];
  assign cnv_evt = !cnv_s && (cnv_cnt == DW'(DEB_CYC - 1));
  assign az_lo   = (az_cnt == DW'(DEB_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_sh <= '1;
      az_sh  <= '1;
    end else begin
      cnv_sh <= {cnv_sh[SYNC_STAGES-2:0], cnv_n};
      az_sh  <= {az_sh[SYNC_STAGES-2:0], az_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_cnt <= '0;
      az_cnt  <= '0;
    end else begin
      if (cnv_s)
        cnv_cnt <= '0;
      else if (cnv_cnt != DW'(DEB_CYC))
        cnv_cnt <= cnv_cnt + 1'b1;
      if (az_s)
        az_cnt <= '0;
      else if (az_cnt != DW'(DEB_CYC))
        az_cnt <= az_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_ZERO;
      tmr     <= '0;
      hold    <= '0;
      out_r   <= '0;
      start_r <= 1'b0;
    end else begin
      start_r <= 1'b0;
      if (az_lo) begin
        st  <= ST_ZERO;
        tmr <= '0;
      end else begin
        case (st)
          ST_ZERO:
            if (tmr == TW'(ZERO_CYC - 1)) begin
              st  <= ST_LO;
              tmr <= '0;
            end else begin
              tmr <= tmr + 1'b1;
            end
          ST_BUSY:
            if (core_done) begin
              hold  <= core_result[2*BYTE_W-1:0];
              out_r <= core_result[3*BYTE_W-1:2*BYTE_W];
              st    <= ST_HI;
            end
          ST_HI:
            if (cnv_evt) begin
              out_r <= hold[2*BYTE_W-1:BYTE_W];
              st    <= ST_MID;
            end
          ST_MID:
            if (cnv_evt) begin
              out_r <= hold[BYTE_W-1:0];
              st    <= ST_LO;
            end
          ST_LO:
            if (cnv_evt) begin
              st      <= ST_BUSY;
              start_r <= 1'b1;
            end
          default: st <= ST_ZERO;
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      ST_HI:   stat = 2'b01;
      ST_MID:  stat = 2'b10;
      ST_LO:   stat = 2'b11;
      default: stat = 2'b00;
    endcase
  end

  assign stat_en    = !((st == ST_ZERO) && (tmr < TW'(FLOAT_CYC)));
  assign core_zero  = (st == ST_ZERO);
  assign core_start = start_r;
  assign data_q     = out_r;
  assign bus_en     = !oe_n;

endmodule

// File: rtl/cnv_byte_seq_chk.sv
module cnv_byte_seq_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                core_start,
  input logic                core_zero,
  input logic                core_done,
  input logic [3*BYTE_W-1:0] core_result,
  input logic [BYTE_W-1:0]   data_q,
  input logic [1:0]          stat,
  input logic                stat_en,
  input logic                az_lo
);

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start); // R2

  AST_START_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> (stat == 2'b00 && !core_zero && stat_en)); // R2

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_zero && stat == 2'b00 && !core_done) |=> (stat == 2'b00)); // R3

  AST_DONE_LOADS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && !core_zero && stat == 2'b00 && !az_lo) |=>
      (stat == 2'b01 && data_q == $past(core_result[3*BYTE_W-1:2*BYTE_W]))); // R4

  AST_HI_TO_MID: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat) == 2'b01 && $past(stat_en) && stat != 2'b01 && !core_zero) |->
      (stat == 2'b10)); // R5

  AST_FLOAT_IN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_en |-> core_zero); // R7

  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_en && $past(stat_en) && stat == $past(stat)) |-> $stable(data_q)); // R10

endmodule

bind cnv_byte_seq cnv_byte_seq_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_start(core_start), .core_zero(core_zero),
  .core_done(core_done), .core_result(core_result), .data_q(data_q),
  .stat(stat), .stat_en(stat_en), .az_lo(az_lo)
);

// File: tb/cnv_byte_seq_bench.sv
module cnv_byte_seq_bench;
  localparam int BW = 8;
  localparam int DEB = 4;
  localparam int FLT = 5;
  localparam int ZRO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv_n = 1'b1, az_n = 1'b1, oe_n = 1'b1, core_done = 1'b0;
  logic [3*BW-1:0] core_result = '0;
  logic core_start, core_zero, bus_en, stat_en;
  logic [BW-1:0] data_q;
  logic [1:0] stat;
  int n_run = 0, n_fail = 0, starts = 0;

  always #2.5 clk = ~clk;

  cnv_byte_seq #(.BYTE_W(BW), .SYNC_STAGES(2), .DEB_CYC(DEB),
                 .FLOAT_CYC(FLT), .ZERO_CYC(ZRO)) u_cnv_byte_seq (
    .clk(clk), .rst_n(rst_n), .cnv_n(cnv_n), .az_n(az_n), .oe_n(oe_n),
    .core_result(core_result), .core_done(core_done), .core_start(core_start),
    .core_zero(core_zero), .data_q(data_q), .bus_en(bus_en), .stat(stat),
    .stat_en(stat_en));

  always @(posedge clk) if (core_start) starts <= starts + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_cnv(input int len);
    @(negedge clk);
    cnv_n = 1'b0;
    wait_cyc(len);
    cnv_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic pulse_done();
    @(negedge clk);
    core_done = 1'b1;
    @(negedge clk);
    core_done = 1'b0;
    wait_cyc(1);
  endtask

  function automatic logic [23:0] pick(input int i);
    case (i)
      0: pick = 24'h000000;
      1: pick = 24'hFFFFFF;
      2: pick = 24'h200000;
      3: pick = 24'h3FFFFF;
      default: pick = 24'((i * 32'h002B3C5D) ^ (i << 13));
    endcase
  endfunction

  task automatic convert_read(input logic [23:0] v, input bit toggle_oe);
    int s0;
    s0 = starts;
    pulse_cnv(DEB);
    check("R2 status after start", 32'(stat), 32'h0);
    check("R2 one start strobe", 32'(starts), 32'(s0 + 1));
    pulse_cnv(DEB);
    check("R3 pulse while busy status", 32'(stat), 32'h0);
    check("R3 pulse while busy no start", 32'(starts), 32'(s0 + 1));
    core_result = v;
    pulse_done();
    check("R4 status 01", 32'(stat), 32'h1);
    check("R4 high byte", 32'(data_q), 32'(v[23:16]));
    if (toggle_oe) oe_n = ~oe_n;
    @(negedge clk);
    check("R6 bus enable", 32'(bus_en), 32'(!oe_n));
    check("R6 data independent of oe", 32'(data_q), 32'(v[23:16]));
    core_result = ~v;
    pulse_done();
    check("R3 stray done status", 32'(stat), 32'h1);
    check("R10 stray done data", 32'(data_q), 32'(v[23:16]));
    pulse_cnv(DEB);
    check("R5 status 10", 32'(stat), 32'h2);
    check("R5 middle byte", 32'(data_q), 32'(v[15:8]));
    pulse_cnv(DEB - 1);
    check("R1 short pulse status", 32'(stat), 32'h2);
    check("R10 short pulse data", 32'(data_q), 32'(v[15:8]));
    pulse_cnv(DEB + 3);
    check("R5 status 11", 32'(stat), 32'h3);
    check("R5 low byte", 32'(data_q), 32'(v[7:0]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    check("R9 float after reset", 32'(stat_en), 32'h0);
    check("R9 zeroing after reset", 32'(core_zero), 32'h1);
    wait_cyc(FLT + 2);
    check("R7 status driven", 32'(stat_en), 32'h1);
    check("R7 status low", 32'(stat), 32'h0);
    pulse_cnv(DEB);
    check("R3 pulse in zeroing", 32'(stat), 32'h0);
    check("R3 pulse in zeroing no start", 32'(starts), 32'h0);
    wait_cyc(10);
    check("R8 ready after zeroing", 32'(stat), 32'h3);
    check("R9 data after reset", 32'(data_q), 32'h0);
    check("R7 status driven when ready", 32'(stat_en), 32'h1);
    oe_n = 1'b1;
    @(negedge clk);
    check("R6 bus off", 32'(bus_en), 32'h0);
    oe_n = 1'b0;
    @(negedge clk);
    check("R6 bus on", 32'(bus_en), 32'h1);
    pulse_cnv(DEB - 1);
    check("R1 short pulse ignored", 32'(stat), 32'h3);
    check("R1 short pulse no start", 32'(starts), 32'h0);

    for (int i = 0; i < 16; i++) convert_read(pick(i), i[0]);

    pulse_cnv(DEB);
    core_result = 24'hA5C33C;
    pulse_done();
    check("R4 before zeroing", 32'(stat), 32'h1);
    @(negedge clk);
    az_n = 1'b0;
    wait_cyc(DEB + 3);
    check("R7 float on request", 32'(stat_en), 32'h0);
    check("R7 zeroing on request", 32'(core_zero), 32'h1);
    wait_cyc(25);
    check("R8 held low extends", 32'(core_zero), 32'h1);
    az_n = 1'b1;
    wait_cyc(3);
    check("R7 float after release", 32'(stat_en), 32'h0);
    wait_cyc(FLT + 2);
    check("R7 driven after float", 32'(stat_en), 32'h1);
    check("R7 driven low", 32'(stat), 32'h0);
    wait_cyc(ZRO - FLT - 8);
    check("R8 not yet ready", 32'(stat), 32'h0);
    wait_cyc(8);
    check("R8 ready at end", 32'(stat), 32'h3);
    check("R10 data kept through zeroing", 32'(data_q), 32'hA5);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule